// File: doc/BRIEF.md
# Per-Core Interrupt Delivery Interface

This block sits between an interrupt distributor and one processor core. Each cycle the distributor offers its best pending candidate: a valid flag, an interrupt ID, a source CPU number and an 8-bit priority. The block registers that candidate. It then decides whether to raise the core's single IRQ line by checking three things: the per-core priority mask, the binary-point split of the priority, and the priority of the interrupt the core is already servicing.

Software drives the block through a small register port. The acknowledge register returns the candidate and makes it active on this core. The end-of-interrupt register retires the most recent active interrupt. A short stack of active group priorities lets a more urgent interrupt preempt a handler that is already running, and lets the earlier level resume when the urgent one is retired. A one-cycle pulse carrying the interrupt ID goes back to the distributor for each accepted acknowledge and for each accepted end-of-interrupt.

Top module: `irq_cpu_if`

Register addresses on `regAddr`: 0 control (bit 0 is the enable), 1 priority mask, 2 binary point, 3 running priority (read-only), 4 acknowledge (read), 5 end-of-interrupt (write).

## Requirements
- R1: A candidate can raise `irqOut` only if its priority is strictly less than the mask. A mask of 0xFF passes every priority except 0xFF. A mask of 0x00 blocks every priority.
- R2: After reset the control enable bit (address 0, bit 0) is 0. While it is 0, `irqOut` stays low.
- R3: A read of address 4 while `irqOut` is high returns the interrupt ID in bits [9:0] and the source CPU in bits [12:10]. Bits [31:13] read as zero.
- R4: An acknowledge read taken while `irqOut` is high makes that interrupt active. In the next cycle `ackPulse` is high for one cycle with `ackId` equal to the ID that was returned.
- R5: A read of address 4 while `irqOut` is low returns 1023 (bits [9:0] all ones, other bits zero). It raises no `ackPulse` and leaves the running priority unchanged.
- R6: A write to address 5 whose bits [9:0] equal the most recently acknowledged, still-active ID retires that interrupt. In the next cycle `eoiPulse` is high with `eoiId` equal to that ID. The running priority returns to the level below it, or to 0xFF when nothing remains active.
- R7: A write to address 5 whose ID does not match the most recent active ID is ignored. No `eoiPulse` follows and the running priority does not change.
- R8: Let the binary point be b (0..7). The group priority is the priority ANDed with 0xFE shifted left by b. A candidate preempts only if its group priority is strictly less than the running priority. Differences in the subpriority bits alone never cause preemption.
- R9: Address 3 reads the group priority of the most recent active interrupt, or 0xFF when none is active. Writes to address 3 have no effect.
- R10: `irqOut` is a function of the registered candidate, so it follows a candidate change one cycle later. If the candidate stays the same, `irqOut` is low in the cycle after that candidate is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| candValid | input | 1 | Distributor has a candidate |
| candId | input | 10 | Candidate interrupt ID |
| candCpu | input | 3 | Candidate source CPU number |
| candPrio | input | 8 | Candidate priority, lower value is more urgent |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the cycle of the read |
| irqOut | output | 1 | Interrupt request line to the core |
| ackPulse | output | 1 | Acknowledge notice to the distributor |
| ackId | output | 10 | ID that was acknowledged |
| eoiPulse | output | 1 | End-of-interrupt notice to the distributor |
| eoiId | output | 10 | ID that was retired |

## Verification
Two events can land in the same cycle: the distributor replaces its candidate, and software reads the acknowledge register. The bench provokes this by changing the candidate inputs in the very cycle it issues the acknowledge read. It then expects the read data and `ackId` to carry the earlier, registered candidate. It also expects the new, more urgent candidate to raise `irqOut` one cycle later as a preemption. A second overlap is a preemption arriving while an earlier handler is still active. That case is judged by the running-priority readback as the nested levels are retired one by one, including an end-of-interrupt with a mismatched ID that must leave the stack untouched.

// File: rtl/irq_cif_pkg.sv
package irq_cif_pkg;
  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_PMASK = 3'd1;
  localparam logic [2:0] ADDR_BPT = 3'd2;
  localparam logic [2:0] ADDR_RUNP = 3'd3;
  localparam logic [2:0] ADDR_ACK = 3'd4;
  localparam logic [2:0] ADDR_EOI = 3'd5;

  typedef struct packed {
    logic ctrlWr;
    logic pmaskWr;
    logic bptWr;
    logic ackRd;
    logic eoiWr;
  } cifStrobes_t;
endpackage

// File: rtl/irq_cif_ctrl.sv
module irq_cif_ctrl
  import irq_cif_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [2:0]  regAddr,
  output cifStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    strobes.ctrlWr  = regWrEn && (regAddr == ADDR_CTRL);
    strobes.pmaskWr = regWrEn && (regAddr == ADDR_PMASK);
    strobes.bptWr   = regWrEn && (regAddr == ADDR_BPT);
    strobes.eoiWr   = regWrEn && (regAddr == ADDR_EOI);
    strobes.ackRd   = regRdEn && (regAddr == ADDR_ACK);
  end

  // R9: the running-priority address never produces a write strobe
  p_runp_no_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_RUNP) |-> (strobes == '0));
endmodule

// File: rtl/irq_cif_dp.sv
module irq_cif_dp
  import irq_cif_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int CPU_W  = 3,
  parameter int PRIO_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  cifStrobes_t       strobes,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  input  logic              candValidIn,
  input  logic [ID_W-1:0]   candIdIn,
  input  logic [CPU_W-1:0]  candCpuIn,
  input  logic [PRIO_W-1:0] candPrioIn,
  output logic [31:0]       regRdata,
  output logic              irqOut,
  output logic              ackPulse,
  output logic [ID_W-1:0]   ackId,
  output logic              eoiPulse,
  output logic [ID_W-1:0]   eoiId
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ID_W-1:0] SPURIOUS = '1;

  logic              enable;
  logic [PRIO_W-1:0] pmask;
  logic [2:0]        bpt;
  logic              candValid;
  logic [ID_W-1:0]   candId;
  logic [CPU_W-1:0]  candCpu;
  logic [PRIO_W-1:0] candPrio;

  logic [PRIO_W-1:0] stkPrio [DEPTH];
  logic [ID_W-1:0]   stkId [DEPTH];
  logic [CNT_W-1:0]  depth;
  logic [CNT_W-1:0]  topIdx;
  logic [PRIO_W-1:0] groupMask;
  logic [PRIO_W-1:0] candGroup;
  logic [PRIO_W-1:0] runPrio;
  logic [ID_W-1:0]   topId;
  logic              stackFull;
  logic              doAck;
  logic              doEoi;
  logic [31:0]       ackWord;

  assign groupMask = ({PRIO_W{1'b1}} << 1) << bpt;
  assign candGroup = candPrio & groupMask;
  assign topIdx    = depth - CNT_W'(1);
  assign runPrio   = (depth == '0) ? '1 : stkPrio[topIdx[IDX_W-1:0]];
  assign topId     = (depth == '0) ? '0 : stkId[topIdx[IDX_W-1:0]];
  assign stackFull = (depth == CNT_W'(DEPTH));

  assign irqOut = enable && candValid && !stackFull &&
                  (candPrio < pmask) && (candGroup < runPrio);

  assign doAck = strobes.ackRd && irqOut;
  assign doEoi = strobes.eoiWr && (depth != '0) && (regWdata[ID_W-1:0] == topId);

  assign ackWord = irqOut ? 32'({candCpu, candId}) : 32'(SPURIOUS);

  always_comb begin
    case (regAddr)
      ADDR_CTRL:  regRdata = 32'(enable);
      ADDR_PMASK: regRdata = 32'(pmask);
      ADDR_BPT:   regRdata = 32'(bpt);
      ADDR_RUNP:  regRdata = 32'(runPrio);
      ADDR_ACK:   regRdata = ackWord;
      default:    regRdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable    <= 1'b0;
      pmask     <= '0;
      bpt       <= '0;
      candValid <= 1'b0;
      candId    <= '0;
      candCpu   <= '0;
      candPrio  <= '1;
      depth     <= '0;
      ackPulse  <= 1'b0;
      ackId     <= '0;
      eoiPulse  <= 1'b0;
      eoiId     <= '0;
    end else begin
      candValid <= candValidIn;
      candId    <= candIdIn;
      candCpu   <= candCpuIn;
      candPrio  <= candPrioIn;
      ackPulse  <= doAck;
      eoiPulse  <= doEoi;
      if (strobes.ctrlWr)  enable <= regWdata[0];
      if (strobes.pmaskWr) pmask  <= regWdata[PRIO_W-1:0];
      if (strobes.bptWr)   bpt    <= regWdata[2:0];
      if (doAck) begin
        ackId <= candId;
        depth <= depth + CNT_W'(1);
      end else if (doEoi) begin
        eoiId <= topId;
        depth <= depth - CNT_W'(1);
      end
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stack
      always_ff @(posedge clk) begin
        if (!rstN) begin
          stkPrio[i] <= '1;
          stkId[i]   <= '0;
        end else if (doAck && depth == CNT_W'(i)) begin
          stkPrio[i] <= candGroup;
          stkId[i]   <= candId;
        end
      end
    end
  endgenerate

  // R2: no request while the interface is disabled
  p_irq_needs_enable_r2: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> enable);

  // R4: an accepted acknowledge leaves a non-idle running priority
  p_ack_sets_active_r4: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> (depth != '0 && runPrio != '1));

  // R5: a spurious acknowledge changes no active state
  p_spurious_no_change_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ackRd && !irqOut) |=> ($stable(depth) && !ackPulse));

  // R6: a retire pulse always follows a one-level pop
  p_eoi_pops_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eoiPulse) |-> (depth == $past(depth) - CNT_W'(1)));

  // R10: with an unchanged candidate the request falls after acknowledge
  p_irq_drops_r10: assert property (@(posedge clk) disable iff (!rstN)
    (doAck && candValidIn == candValid && candIdIn == candId &&
     candPrioIn == candPrio) |=> !irqOut);
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
  import irq_cif_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int CPU_W  = 3,
  parameter int PRIO_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              candValid,
  input  logic [ID_W-1:0]   candId,
  input  logic [CPU_W-1:0]  candCpu,
  input  logic [PRIO_W-1:0] candPrio,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irqOut,
  output logic              ackPulse,
  output logic [ID_W-1:0]   ackId,
  output logic              eoiPulse,
  output logic [ID_W-1:0]   eoiId
);
  cifStrobes_t strobes;

  irq_cif_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  irq_cif_dp #(
    .ID_W(ID_W), .CPU_W(CPU_W), .PRIO_W(PRIO_W), .DEPTH(DEPTH)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .regAddr     (regAddr),
    .regWdata    (regWdata),
    .candValidIn (candValid),
    .candIdIn    (candId),
    .candCpuIn   (candCpu),
    .candPrioIn  (candPrio),
    .regRdata    (regRdata),
    .irqOut      (irqOut),
    .ackPulse    (ackPulse),
    .ackId       (ackId),
    .eoiPulse    (eoiPulse),
    .eoiId       (eoiId)
  );
endmodule

// File: tb/irq_cpu_if_tb.sv
module irq_cpu_if_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        candValid = 1'b0;
  logic [9:0]  candId = '0;
  logic [2:0]  candCpu = '0;
  logic [7:0]  candPrio = 8'hFF;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqOut, ackPulse, eoiPulse;
  logic [9:0]  ackId, eoiId;

  int nChecks = 0;
  int nFails = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  irq_cpu_if u_dut (
    .clk(clk), .rstN(rstN), .candValid(candValid), .candId(candId),
    .candCpu(candCpu), .candPrio(candPrio), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut), .ackPulse(ackPulse),
    .ackId(ackId), .eoiPulse(eoiPulse), .eoiId(eoiId)
  );

  // {mask, binary point, active prio (FF = none), candidate prio, expected irq}
  localparam logic [39:0] VEC [12] = '{
    {8'hFF, 8'd0, 8'hFF, 8'hFE, 8'd1},  // R1
    {8'hFF, 8'd0, 8'hFF, 8'hFF, 8'd0},  // R1
    {8'h00, 8'd0, 8'hFF, 8'h00, 8'd0},  // R1
    {8'h80, 8'd0, 8'hFF, 8'h7F, 8'd1},  // R1
    {8'h80, 8'd0, 8'hFF, 8'h80, 8'd0},  // R1
    {8'hFF, 8'd0, 8'h40, 8'h3F, 8'd1},  // R8
    {8'hFF, 8'd0, 8'h40, 8'h41, 8'd0},  // R8
    {8'hFF, 8'd3, 8'h40, 8'h38, 8'd1},  // R8
    {8'hFF, 8'd4, 8'h50, 8'h48, 8'd0},  // R8 subpriority only
    {8'hFF, 8'd4, 8'h50, 8'h3F, 8'd1},  // R8
    {8'hFF, 8'd7, 8'h50, 8'h00, 8'd0},  // R8 no group bits
    {8'h10, 8'd0, 8'h40, 8'h20, 8'd0}   // R1 mask wins over preemption
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdata;
    tick();
    regRdEn = 1'b0;
  endtask

  task automatic setCand(logic v, logic [9:0] id, logic [2:0] cpu, logic [7:0] p);
    candValid = v; candId = id; candCpu = cpu; candPrio = p;
    tick();
  endtask

  initial begin
    #(200000 * 8);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    // reset state
    check("R2 reset irq", 32'(irqOut), 0);
    rd(3'd0, rv); check("R2 reset enable", rv, 0);
    rd(3'd3, rv); check("R9 idle running prio", rv, 32'hFF);

    // disabled: candidate present but no request, spurious ack
    wr(3'd1, 32'hFF);
    setCand(1, 10'd7, 3'd2, 8'h10);
    check("R2 disabled irq", 32'(irqOut), 0);
    rd(3'd4, rv); check("R5 spurious id", rv, 32'd1023);
    check("R5 no ack pulse", 32'(ackPulse), 0);
    rd(3'd3, rv); check("R5 state unchanged", rv, 32'hFF);

    // enable and acknowledge
    wr(3'd0, 32'd1);
    check("R2 enabled irq", 32'(irqOut), 1);
    rd(3'd4, rv); check("R3 ack word", rv, 32'h807);
    check("R4 ack pulse", 32'(ackPulse), 1);
    check("R4 ack id", 32'(ackId), 7);
    check("R10 irq drops after ack", 32'(irqOut), 0);
    tick();
    check("R4 ack pulse single", 32'(ackPulse), 0);
    rd(3'd3, rv); check("R9 running prio", rv, 32'h10);
    wr(3'd3, 32'h55);
    rd(3'd3, rv); check("R9 read-only", rv, 32'h10);

    // nested preemption
    setCand(1, 10'd12, 3'd0, 8'h08);
    check("R8 preempt irq", 32'(irqOut), 1);
    rd(3'd4, rv); check("R3 nested ack word", rv, 32'd12);
    rd(3'd3, rv); check("R9 nested running prio", rv, 32'h08);
    wr(3'd5, 32'd7);
    check("R7 mismatched eoi no pulse", 32'(eoiPulse), 0);
    rd(3'd3, rv); check("R7 mismatched eoi ignored", rv, 32'h08);
    wr(3'd5, 32'd12);
    check("R6 eoi pulse", 32'(eoiPulse), 1);
    check("R6 eoi id", 32'(eoiId), 12);
    rd(3'd3, rv); check("R6 back to outer level", rv, 32'h10);
    wr(3'd5, 32'd7);
    rd(3'd3, rv); check("R6 idle after last eoi", rv, 32'hFF);

    // candidate change in the same cycle as acknowledge
    setCand(1, 10'd20, 3'd1, 8'h30);
    check("R10 irq follows candidate", 32'(irqOut), 1);
    regRdEn = 1'b1; regAddr = 3'd4;
    candId = 10'd21; candPrio = 8'h20;
    #1 rv = regRdata;
    tick();
    regRdEn = 1'b0;
    check("R3 ack returns registered candidate", rv, 32'h414);
    check("R4 ack id registered candidate", 32'(ackId), 20);
    check("R8 new candidate preempts", 32'(irqOut), 1);
    rd(3'd3, rv); check("R9 running prio after overlap", rv, 32'h30);
    wr(3'd5, 32'd20);
    rd(3'd3, rv); check("R6 overlap retired", rv, 32'hFF);
    setCand(0, 10'd0, 3'd0, 8'hFF);
    rd(3'd4, rv); check("R5 spurious with no candidate", rv, 32'd1023);

    // vector walk over mask and binary-point cases
    foreach (VEC[i]) begin
      logic [7:0] vm, vb, va, vc, ve;
      {vm, vb, va, vc, ve} = VEC[i];
      wr(3'd2, 32'(vb));
      wr(3'd1, 32'hFF);
      if (va != 8'hFF) begin
        setCand(1, 10'd5, 3'd0, va);
        rd(3'd4, rv);
      end
      setCand(1, 10'd9, 3'd1, vc);
      wr(3'd1, 32'(vm));
      check($sformatf("R1/R8 vector %0d irq", i), 32'(irqOut), 32'(ve));
      setCand(0, 10'd0, 3'd0, 8'hFF);
      if (va != 8'hFF) wr(3'd5, 32'd5);
      rd(3'd3, rv);
      check($sformatf("R6 vector %0d cleanup", i), rv, 32'hFF);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule